// File: doc/BRIEF.md
# Priority-Aware Pause Transmit Gate

This block sits between a two-queue transmit scheduler (one high-priority queue, one low-priority queue) and the media-access transmit engine. It reacts to decoded incoming flow control frames of two kinds. A full pause stops every new frame start at the media-access level. A low pause only stops the scheduler from fetching low-priority frames. Frames already sitting in the transmit FIFO, whichever queue they came from, still go out during a low pause.

Each accepted frame loads its pause time into a down-counter that decrements once per slot-time tick. Pause ends when the counter reaches zero. Every accepted frame completely replaces the pause state and count left by the one before it. A pause time of zero therefore releases the gate at once. Two configuration bits are honoured. One enables reaction to received pause frames. The other keeps pause frames out of the receive FIFO. A third input caps the transmit FIFO occupancy that the scheduler is allowed to build up. With priority pausing this cap is normally set to two frames.

Top module: `pfc_tx_gate`

## Requirements
- R1: After synchronous reset, `pause_state` is 2'b00, `pause_left` is zero and `tx_hold` is low. Both dequeue enables are high whenever the FIFO has room.
- R2: An accepted frame with `fc_low`=0 and a nonzero time sets `pause_state` to 2'b10 (full pause) on the next cycle. In that state `tx_hold` is high and `lp_deq_en` is low.
- R3: An accepted frame with `fc_low`=1 and a nonzero time sets `pause_state` to 2'b01 (low pause) on the next cycle. In that state `tx_hold` is low, `lp_deq_en` is low and `hp_deq_en` follows FIFO room only.
- R4: An accepted frame replaces both the pause kind and the remaining count, whatever the previous state was. This covers low to full, full to low, and the same kind again.
- R5: An accepted frame of either kind whose pause time is zero returns `pause_state` to 2'b00 and `pause_left` to zero on the next cycle.
- R6: While paused, each `slot_tick` cycle lowers `pause_left` by one. The tick that takes it from 1 to 0 also returns `pause_state` to 2'b00. With no pause active, ticks change nothing.
- R7: When an accepted frame and a `slot_tick` fall in the same cycle, the frame wins. `pause_left` takes the new time undecremented.
- R8: With `cfg_fc_en` low, received frames leave `pause_state` and `pause_left` untouched. An existing pause keeps counting down.
- R9: `rx_fwd` is high exactly in cycles where `fc_valid` is high and `cfg_fc_reject` is low. This holds independently of `cfg_fc_en`.
- R10: Both dequeue enables are low when `fifo_frames` is at or above the effective cap. The effective cap is `cfg_fifo_cap` clamped to FIFO_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_fc_en | input | 1 | Enable reaction to received pause frames |
| cfg_fc_reject | input | 1 | Keep pause frames out of the receive FIFO |
| cfg_fifo_cap | input | FW | Maximum transmit FIFO occupancy in frames |
| fc_valid | input | 1 | One-cycle pulse per received pause frame |
| fc_low | input | 1 | 1: low pause, 0: full pause |
| fc_time | input | TIME_W | Pause time in slot times |
| slot_tick | input | 1 | One pulse per slot time |
| fifo_frames | input | FW | Frames currently in the transmit FIFO |
| hp_deq_en | output | 1 | High-priority queue may be fetched |
| lp_deq_en | output | 1 | Low-priority queue may be fetched |
| tx_hold | output | 1 | Hold off new frame starts at the MAC |
| pause_state | output | 2 | 00 none, 01 low pause, 10 full pause |
| pause_left | output | TIME_W | Remaining pause slot times |
| rx_fwd | output | 1 | Forward the current pause frame to the receive FIFO |

## Verification
The two functions that can land in the same cycle are a frame load and a countdown tick. This includes a tick that would take the counter from one to zero. Random stimulus raises frames and ticks independently, so they coincide often. A directed case puts a new frame on the exact cycle of the expiring tick. The bench's reference model applies the load ahead of the decrement. It judges the result by `pause_state` and `pause_left` one cycle later.

// File: rtl/pfc_gate_pkg.sv
package pfc_gate_pkg;

   typedef enum logic [1:0] {
      PS_NONE = 2'b00,
      PS_LOW  = 2'b01,
      PS_FULL = 2'b10
   } pause_state_e;

endpackage

// File: rtl/pfc_fc_qualify.sv
module pfc_fc_qualify
   import pfc_gate_pkg::*;
#(
   parameter int TIME_W = 16
) (
   input  logic              fc_valid,
   input  logic              fc_low,
   input  logic [TIME_W-1:0] fc_time,
   input  logic              cfg_fc_en,
   input  logic              cfg_fc_reject,
   output logic              load,
   output pause_state_e      load_state,
   output logic [TIME_W-1:0] load_time,
   output logic              rx_fwd
);

   logic zero_time;

   always_comb begin
      zero_time = (fc_time == '0);
      load      = fc_valid & cfg_fc_en;
      load_time = fc_time;
      if (zero_time)
         load_state = PS_NONE;
      else if (fc_low)
         load_state = PS_LOW;
      else
         load_state = PS_FULL;
      rx_fwd = fc_valid & ~cfg_fc_reject;
   end

endmodule

// File: rtl/pfc_pause_timer.sv
module pfc_pause_timer
   import pfc_gate_pkg::*;
#(
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  pause_state_e      load_state,
   input  logic [TIME_W-1:0] load_time,
   input  logic              slot_tick,
   output pause_state_e      state,
   output logic [TIME_W-1:0] left
);

   localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

   pause_state_e      state_q;
   logic [TIME_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= PS_NONE;
         left_q  <= '0;
      end else if (load) begin
         state_q <= load_state;
         left_q  <= load_time;
      end else if (slot_tick && state_q != PS_NONE) begin
         if (left_q == ONE) begin
            state_q <= PS_NONE;
            left_q  <= '0;
         end else begin
            left_q <= left_q - ONE;
         end
      end
   end

   assign state = state_q;
   assign left  = left_q;

   a_r4_state_legal: assert property (@(posedge clk) disable iff (rst)
      state_q != 2'b11);

   a_r6_zero_iff_none: assert property (@(posedge clk) disable iff (rst)
      (left_q == '0) == (state_q == PS_NONE));

   a_r6_tick_dec: assert property (@(posedge clk) disable iff (rst)
      (!load && slot_tick && state_q != PS_NONE && left_q > ONE)
      |=> left_q == $past(left_q) - ONE);

   a_r5_zero_clears: assert property (@(posedge clk) disable iff (rst)
      (load && load_time == '0) |=> state_q == PS_NONE);

   a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
      (load && slot_tick) |=> left_q == $past(load_time));

endmodule

// File: rtl/pfc_fetch_gate.sv
module pfc_fetch_gate
   import pfc_gate_pkg::*;
#(
   parameter int FIFO_DEPTH = 4,
   parameter bit CAP_EN     = 1'b1,
   parameter int FW         = $clog2(FIFO_DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst,
   input  pause_state_e state,
   input  logic [FW-1:0] fifo_frames,
   input  logic [FW-1:0] cfg_fifo_cap,
   output logic         hp_deq_en,
   output logic         lp_deq_en,
   output logic         tx_hold
);

   localparam logic [FW-1:0] DEPTH_V = FW'(FIFO_DEPTH);

   logic          room;
   logic [FW-1:0] eff_cap;

   generate
      if (CAP_EN) begin : g_cap
         always_comb begin
            eff_cap = (cfg_fifo_cap > DEPTH_V) ? DEPTH_V : cfg_fifo_cap;
            room    = fifo_frames < eff_cap;
         end
      end else begin : g_nocap
         always_comb begin
            eff_cap = DEPTH_V;
            room    = fifo_frames < DEPTH_V;
         end
      end
   endgenerate

   always_comb begin
      tx_hold   = (state == PS_FULL);
      hp_deq_en = room;
      lp_deq_en = room && (state == PS_NONE);
   end

   a_r2_hold_blocks_lp: assert property (@(posedge clk) disable iff (rst)
      tx_hold |-> !lp_deq_en);

   a_r10_no_overfill: assert property (@(posedge clk) disable iff (rst)
      (fifo_frames >= eff_cap) |-> !(hp_deq_en || lp_deq_en));

   a_r3_low_no_hold: assert property (@(posedge clk) disable iff (rst)
      (state == PS_LOW) |-> (!tx_hold && !lp_deq_en));

endmodule

// File: rtl/pfc_tx_gate.sv
module pfc_tx_gate
   import pfc_gate_pkg::*;
#(
   parameter int TIME_W     = 16,
   parameter int FIFO_DEPTH = 4,
   parameter bit CAP_EN     = 1'b1,
   parameter int FW         = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_fc_en,
   input  logic              cfg_fc_reject,
   input  logic [FW-1:0]     cfg_fifo_cap,
   input  logic              fc_valid,
   input  logic              fc_low,
   input  logic [TIME_W-1:0] fc_time,
   input  logic              slot_tick,
   input  logic [FW-1:0]     fifo_frames,
   output logic              hp_deq_en,
   output logic              lp_deq_en,
   output logic              tx_hold,
   output logic [1:0]        pause_state,
   output logic [TIME_W-1:0] pause_left,
   output logic              rx_fwd
);

   generate
      if (TIME_W < 2) begin : g_bad_time_w
         $error("pfc_tx_gate: TIME_W must be at least 2");
      end
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("pfc_tx_gate: FIFO_DEPTH must be at least 2");
      end
      if (FW < $clog2(FIFO_DEPTH + 1)) begin : g_bad_fw
         $error("pfc_tx_gate: FW too narrow for FIFO_DEPTH");
      end
   endgenerate

   logic              ld;
   pause_state_e      ld_state;
   logic [TIME_W-1:0] ld_time;
   pause_state_e      cur_state;

   pfc_fc_qualify #(.TIME_W(TIME_W)) u_qualify (
      .fc_valid      (fc_valid),
      .fc_low        (fc_low),
      .fc_time       (fc_time),
      .cfg_fc_en     (cfg_fc_en),
      .cfg_fc_reject (cfg_fc_reject),
      .load          (ld),
      .load_state    (ld_state),
      .load_time     (ld_time),
      .rx_fwd        (rx_fwd)
   );

   pfc_pause_timer #(.TIME_W(TIME_W)) u_timer (
      .clk        (clk),
      .rst        (rst),
      .load       (ld),
      .load_state (ld_state),
      .load_time  (ld_time),
      .slot_tick  (slot_tick),
      .state      (cur_state),
      .left       (pause_left)
   );

   pfc_fetch_gate #(.FIFO_DEPTH(FIFO_DEPTH), .CAP_EN(CAP_EN), .FW(FW)) u_fetch (
      .clk          (clk),
      .rst          (rst),
      .state        (cur_state),
      .fifo_frames  (fifo_frames),
      .cfg_fifo_cap (cfg_fifo_cap),
      .hp_deq_en    (hp_deq_en),
      .lp_deq_en    (lp_deq_en),
      .tx_hold      (tx_hold)
   );

   assign pause_state = cur_state;

   a_r8_disabled_ignored: assert property (@(posedge clk) disable iff (rst)
      (fc_valid && !cfg_fc_en && !slot_tick)
      |=> (pause_state == $past(pause_state) && pause_left == $past(pause_left)));

   a_r9_reject_blocks: assert property (@(posedge clk) disable iff (rst)
      cfg_fc_reject |-> !rx_fwd);

endmodule

// File: tb/pfc_tx_gate_tb.sv
module pfc_tx_gate_tb;

   localparam int CLK_PERIOD = 10;
   localparam int TW = 16;
   localparam int DEPTH = 4;
   localparam int FW = 3;

   logic          clk = 1'b0;
   logic          rst;
   logic          cfg_fc_en, cfg_fc_reject;
   logic [FW-1:0] cfg_fifo_cap, fifo_frames;
   logic          fc_valid, fc_low, slot_tick;
   logic [TW-1:0] fc_time;
   logic          hp_deq_en, lp_deq_en, tx_hold, rx_fwd;
   logic [1:0]    pause_state;
   logic [TW-1:0] pause_left;

   int n_tests = 0;
   int n_fail  = 0;
   logic [1:0]    m_st;
   logic [TW-1:0] m_left;
   bit            done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pfc_tx_gate #(.TIME_W(TW), .FIFO_DEPTH(DEPTH), .CAP_EN(1'b1), .FW(FW)) u_dut (
      .clk(clk), .rst(rst), .cfg_fc_en(cfg_fc_en), .cfg_fc_reject(cfg_fc_reject),
      .cfg_fifo_cap(cfg_fifo_cap), .fc_valid(fc_valid), .fc_low(fc_low),
      .fc_time(fc_time), .slot_tick(slot_tick), .fifo_frames(fifo_frames),
      .hp_deq_en(hp_deq_en), .lp_deq_en(lp_deq_en), .tx_hold(tx_hold),
      .pause_state(pause_state), .pause_left(pause_left), .rx_fwd(rx_fwd)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit room_f();
      logic [FW-1:0] c;
      c = (cfg_fifo_cap > FW'(DEPTH)) ? FW'(DEPTH) : cfg_fifo_cap;
      return fifo_frames < c;
   endfunction

   // Compare all outputs against the reference model, inputs already applied.
   task automatic check_all();
      chk("R4 pause_state", 32'(pause_state), 32'(m_st));
      chk("R6 pause_left", 32'(pause_left), 32'(m_left));
      chk("R2 tx_hold", 32'(tx_hold), 32'(m_st == 2'b10));
      chk("R3 lp_deq_en", 32'(lp_deq_en), 32'(room_f() && m_st == 2'b00));
      chk("R10 hp_deq_en", 32'(hp_deq_en), 32'(room_f()));
      chk("R9 rx_fwd", 32'(rx_fwd), 32'(fc_valid && !cfg_fc_reject));
   endtask

   function automatic void model_step();
      if (fc_valid && cfg_fc_en) begin
         if (fc_time == '0) begin m_st = 2'b00; m_left = '0; end
         else begin m_st = fc_low ? 2'b01 : 2'b10; m_left = fc_time; end
      end else if (slot_tick && m_st != 2'b00) begin
         if (m_left == 1) begin m_st = 2'b00; m_left = '0; end
         else m_left = m_left - 1;
      end
   endfunction

   // One cycle: settle, check, clock, update model, clear pulses.
   task automatic cyc();
      #1;
      check_all();
      @(posedge clk);
      model_step();
      #1;
      fc_valid = 0;
      slot_tick = 0;
   endtask

   task automatic frame(input logic low, input logic [TW-1:0] t, input logic tick);
      fc_valid = 1; fc_low = low; fc_time = t; slot_tick = tick;
      cyc();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst = 1; cfg_fc_en = 1; cfg_fc_reject = 0; cfg_fifo_cap = 3'd2;
      fifo_frames = 0; fc_valid = 0; fc_low = 0; fc_time = 0; slot_tick = 0;
      m_st = 2'b00; m_left = '0;
      repeat (3) @(posedge clk);
      #1 rst = 0;
      // R1 reset state
      #1;
      chk("R1 state", 32'(pause_state), 32'd0);
      chk("R1 left", 32'(pause_left), 32'd0);
      chk("R1 hold", 32'(tx_hold), 32'd0);
      chk("R1 lp", 32'(lp_deq_en), 32'd1);
      chk("R1 hp", 32'(hp_deq_en), 32'd1);

      // R2 full pause, then R4 override to low, then low to full
      frame(1'b0, 16'd5, 1'b0);
      chk("R2 full state", 32'(pause_state), 32'd2);
      slot_tick = 1; cyc();
      frame(1'b1, 16'd3, 1'b0);
      chk("R4 full->low", 32'(pause_state), 32'd1);
      chk("R4 left reload", 32'(pause_left), 32'd3);
      frame(1'b0, 16'd9, 1'b0);
      chk("R4 low->full", 32'(tx_hold), 32'd1);
      // R5 zero time clears
      frame(1'b1, 16'd0, 1'b0);
      chk("R5 cleared", 32'(pause_state), 32'd0);
      chk("R5 left", 32'(pause_left), 32'd0);
      // R6 countdown to expiry
      frame(1'b1, 16'd2, 1'b0);
      slot_tick = 1; cyc();
      chk("R6 left 1", 32'(pause_left), 32'd1);
      slot_tick = 1; cyc();
      chk("R6 expired", 32'(pause_state), 32'd0);
      slot_tick = 1; cyc();
      chk("R6 idle tick", 32'(pause_left), 32'd0);
      // R7 frame on the expiring tick
      frame(1'b0, 16'd1, 1'b0);
      frame(1'b1, 16'd4, 1'b1);
      chk("R7 frame wins state", 32'(pause_state), 32'd1);
      chk("R7 frame wins left", 32'(pause_left), 32'd4);
      // R8 disabled: ignored, countdown continues
      cfg_fc_en = 0;
      frame(1'b0, 16'd7, 1'b1);
      chk("R8 ignored state", 32'(pause_state), 32'd1);
      chk("R8 still counts", 32'(pause_left), 32'd3);
      // R9 reject with enable off
      cfg_fc_reject = 1; fc_valid = 1; #1;
      chk("R9 rejected", 32'(rx_fwd), 32'd0);
      cfg_fc_reject = 0; #1;
      chk("R9 forwarded", 32'(rx_fwd), 32'd1);
      fc_valid = 0; cfg_fc_en = 1;
      // R10 cap and clamp
      frame(1'b1, 16'd0, 1'b0);
      fifo_frames = 3'd2; cfg_fifo_cap = 3'd2; #1;
      chk("R10 at cap hp", 32'(hp_deq_en), 32'd0);
      chk("R10 at cap lp", 32'(lp_deq_en), 32'd0);
      fifo_frames = 3'd3; cfg_fifo_cap = 3'd7; #1;
      chk("R10 clamp room", 32'(hp_deq_en), 32'd1);
      fifo_frames = 3'd4; #1;
      chk("R10 clamp full", 32'(hp_deq_en), 32'd0);

      // Constrained random
      for (int i = 0; i < 4000; i++) begin
         fc_valid      = ($urandom_range(0, 5) == 0);
         fc_low        = $urandom_range(0, 1);
         fc_time       = ($urandom_range(0, 7) == 0) ? 16'd0 : 16'($urandom_range(1, 12));
         slot_tick     = $urandom_range(0, 1);
         cfg_fc_en     = ($urandom_range(0, 7) != 0);
         cfg_fc_reject = $urandom_range(0, 1);
         fifo_frames   = 3'($urandom_range(0, 4));
         cfg_fifo_cap  = 3'($urandom_range(0, 7));
         cyc();
      end
      #1;
      check_all();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule